// File: doc/BRIEF.md
# Mode-Gated A20 Address Masking Unit

This block sits on the path from linear address generation to the cache tag lookup. Each request carries a 32-bit address and a two-bit kind code. When the processor is in Real mode and the external A20 force-low input is high, the block clears address bit 20 on program-generated requests (reads and writes). This covers line fills, writethroughs and cache accesses made while another agent owns the bus. Requests that maintain the physical tags (snoop or inquire writebacks, flush and write-back-invalidate sweeps) skip the mask. In Protected, Virtual-8086 and System Management modes the force-low input has no effect.

A bank of four breakpoint comparators, each with an arm bit, checks the effective address after masking. It raises one hit flag per comparator. Requests enter on a valid/ready stream. A single register stage holds the result. An upstream source may only treat a request as taken in a cycle where both `req_valid` and `req_ready` are high. The result stays on the output, unchanged, until the consumer raises `rsp_ready`. While the result waits, `req_ready` is low. The breakpoint write port is a plain control port with no handshake.

Top module: `a20_mask_unit`

## Requirements
- R1: In Real mode (`cpu_mode` 2'b00), with `a20_force_low` high and `req_kind` 2'b00 (read) or 2'b01 (write), the effective address equals the request address with bit 20 forced to 0. All other bits are unchanged.
- R2: In Protected (2'b01), Virtual-8086 (2'b10) or System Management (2'b11) mode, the effective address equals the request address whatever `a20_force_low` is.
- R3: Requests of kind 2'b10 (snoop/inquire) or 2'b11 (flush/invalidate) pass unchanged in every mode, whatever `a20_force_low` is.
- R4: With `a20_force_low` low, every request passes unchanged.
- R5: Bit i of `rsp_bp_hit` is 1 exactly when comparator i is armed and its stored address equals the effective (post-mask) address of that request.
- R6: A disarmed comparator never sets its hit bit, even when its stored address matches.
- R7: A request accepted in one cycle appears with `rsp_valid` high on the next cycle, together with its effective address, kind and hit flags. Results leave in acceptance order.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the output holds its values and `req_ready` is low. Otherwise `req_ready` is high.
- R9: After reset, `rsp_valid` is 0 and all comparators are disarmed.
- R10: A breakpoint write (`bp_wr_en` high) stores an address and an arm bit into the slot `bp_wr_sel`. It applies to requests accepted in later cycles. A request accepted in the same cycle as the write is compared against the previous contents of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_mode | input | 2 | 00 Real, 01 Protected, 10 Virtual-8086, 11 System Management |
| a20_force_low | input | 1 | External request to clear address bit 20 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 00 read, 01 write, 10 snoop/inquire, 11 flush/invalidate |
| req_addr | input | 32 | Linear or physical request address |
| bp_wr_en | input | 1 | Write one breakpoint slot |
| bp_wr_sel | input | 2 | Slot index for the write |
| bp_wr_addr | input | 32 | Breakpoint address to store |
| bp_wr_arm | input | 1 | Arm bit to store |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Effective address |
| rsp_kind | output | 2 | Kind of the request, passed through |
| rsp_bp_hit | output | 4 | Per-comparator hit flags |

## Verification
Each result is due one clock after the cycle in which its request was taken, or later if `rsp_ready` holds it back. The bench settles its inputs shortly after the falling edge and decides then whether a request is taken and whether a result is consumed. It predicts each result from the mode, mask input, kind and its own copy of the breakpoint slots as they stood before that edge. It pops the prediction only in the cycle where `rsp_valid` and `rsp_ready` are both high. A held result is compared with the values from the previous cycle, and `req_ready` is checked every cycle.

// File: rtl/a20m_pkg.sv
package a20m_pkg;

  typedef enum logic [1:0] {
    MODE_REAL  = 2'b00,
    MODE_PROT  = 2'b01,
    MODE_V86   = 2'b10,
    MODE_SMM   = 2'b11
  } cpu_mode_e;

  typedef enum logic [1:0] {
    KIND_RD    = 2'b00,
    KIND_WR    = 2'b01,
    KIND_SNOOP = 2'b10,
    KIND_FLUSH = 2'b11
  } req_kind_e;

  // Linear-tag traffic has the upper kind bit clear.
  function automatic logic kind_is_linear(input logic [1:0] k);
    return (k == KIND_RD) || (k == KIND_WR);
  endfunction

endpackage

// File: rtl/a20m_gate.sv
module a20m_gate
  import a20m_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MASK_BIT = 20
) (
  input  logic [1:0]        mode,
  input  logic              force_low,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam logic [ADDR_W-1:0] CLR_MASK = ~(ADDR_W'(1) << MASK_BIT);

  logic mode_ok;
  logic apply;

  always_comb begin
    mode_ok  = (mode == MODE_REAL);
    apply    = force_low && mode_ok && kind_is_linear(kind);
    addr_out = apply ? (addr_in & CLR_MASK) : addr_in;
  end

endmodule

// File: rtl/a20m_bp_bank.sv
module a20m_bp_bank #(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4,
  localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_arm,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [NUM_BP-1:0] hit
);

  logic [ADDR_W-1:0] slot_addr [NUM_BP];
  logic [NUM_BP-1:0] slot_arm;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[i] <= '0;
        slot_arm[i]  <= 1'b0;
      end else if (wr_en && (wr_sel == IDX_W'(i))) begin
        slot_addr[i] <= wr_addr;
        slot_arm[i]  <= wr_arm;
      end
    end

    always_comb hit[i] = slot_arm[i] && (slot_addr[i] == probe_addr);
  end

endmodule

// File: rtl/a20m_out_stage.sv
module a20m_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  always_comb in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8: a stalled result must not move
  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/a20_mask_unit.sv
module a20_mask_unit
  import a20m_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MASK_BIT = 20,
  parameter int NUM_BP   = 4,
  localparam int IDX_W   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpu_mode,
  input  logic              a20_force_low,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bp_wr_en,
  input  logic [IDX_W-1:0]  bp_wr_sel,
  input  logic [ADDR_W-1:0] bp_wr_addr,
  input  logic              bp_wr_arm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_kind,
  output logic [NUM_BP-1:0] rsp_bp_hit
);

  localparam int PAY_W = ADDR_W + 2 + NUM_BP;

  logic [ADDR_W-1:0] eff_addr;
  logic [NUM_BP-1:0] hit_now;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  a20m_gate #(.ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT)) u_gate (
    .mode     (cpu_mode),
    .force_low(a20_force_low),
    .kind     (req_kind),
    .addr_in  (req_addr),
    .addr_out (eff_addr)
  );

  a20m_bp_bank #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) u_bp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bp_wr_en),
    .wr_sel    (bp_wr_sel),
    .wr_addr   (bp_wr_addr),
    .wr_arm    (bp_wr_arm),
    .probe_addr(eff_addr),
    .hit       (hit_now)
  );

  always_comb pay_in = {req_kind, hit_now, eff_addr};

  a20m_out_stage #(.W(PAY_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (pay_in),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (pay_out)
  );

  always_comb begin
    rsp_addr   = pay_out[ADDR_W-1:0];
    rsp_bp_hit = pay_out[ADDR_W +: NUM_BP];
    rsp_kind   = pay_out[PAY_W-1 -: 2];
  end

  // R7: an accepted request shows up on the next cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2: non-Real modes never alter the address
  a_r2_mode_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cpu_mode != MODE_REAL) |=> (rsp_addr == $past(req_addr)));

  // R3: physical-tag kinds never alter the address
  a_r3_phys_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[1]) |=> (rsp_addr == $past(req_addr)));

  // R1: masked request clears only the mask bit
  a_r1_bit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cpu_mode == MODE_REAL && a20_force_low && !req_kind[1])
      |=> (!rsp_addr[MASK_BIT] && ((rsp_addr ^ $past(req_addr)) & ~(ADDR_W'(1) << MASK_BIT)) == '0));

  // R8: ready is low exactly while a result is stalled
  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

endmodule

// File: tb/a20_mask_unit_bench.sv
module a20_mask_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cpu_mode = 0;
  logic        a20_force_low = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_kind = 0;
  logic [31:0] req_addr = 0;
  logic        bp_wr_en = 0;
  logic [1:0]  bp_wr_sel = 0;
  logic [31:0] bp_wr_addr = 0;
  logic        bp_wr_arm = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_kind;
  logic [3:0]  rsp_bp_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  a20_mask_unit u_a20_mask_unit (.*);

  int checks = 0, failures = 0;
  logic [31:0] m_addr [4];
  logic [3:0]  m_arm;
  typedef struct packed { logic [1:0] kind; logic [3:0] hit; logic [31:0] addr; } exp_t;
  exp_t  q [$];
  string qtag [$];
  logic  held = 0;
  logic [37:0] held_val;

  function automatic logic [31:0] exp_addr(logic [1:0] md, logic f, logic [1:0] k, logic [31:0] a);
    if (md == 2'b00 && f && !k[1]) return a & 32'hFFEF_FFFF;
    return a;
  endfunction

  function automatic logic [3:0] exp_hit(logic [31:0] e);
    logic [3:0] h;
    for (int i = 0; i < 4; i++) h[i] = m_arm[i] && (m_addr[i] == e);
    return h;
  endfunction

  function automatic string tag_of(logic [1:0] md, logic f, logic [1:0] k);
    if (!f) return "R4";
    if (k[1]) return "R3";
    if (md != 2'b00) return "R2";
    return "R1";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(logic v, logic [1:0] md, logic f, logic [1:0] k, logic [31:0] a,
                       logic ordy, logic bw, logic [1:0] bs, logic [31:0] ba, logic barm,
                       string force_tag = "");
    exp_t e;
    @(negedge clk);
    req_valid = v; cpu_mode = md; a20_force_low = f; req_kind = k; req_addr = a;
    rsp_ready = ordy; bp_wr_en = bw; bp_wr_sel = bs; bp_wr_addr = ba; bp_wr_arm = barm;
    #1;
    chk("R8 ready", {63'd0, req_ready}, {63'd0, (!rsp_valid || rsp_ready)});
    if (held) chk("R8 hold", {25'd0, rsp_valid, rsp_kind, rsp_bp_hit, rsp_addr}, {25'd0, 1'b1, held_val});
    if (rsp_valid && rsp_ready) begin
      if (q.size() == 0) chk("R7 spurious", 64'd1, 64'd0);
      else begin
        e = q.pop_front();
        chk(qtag.pop_front(), {26'd0, rsp_kind, rsp_bp_hit, rsp_addr}, {26'd0, e});
      end
    end
    held = rsp_valid && !rsp_ready;
    held_val = {rsp_kind, rsp_bp_hit, rsp_addr};
    if (v && req_ready) begin
      e.addr = exp_addr(md, f, k, a);
      e.kind = k;
      e.hit  = exp_hit(e.addr);
      q.push_back(e);
      qtag.push_back(force_tag != "" ? force_tag : tag_of(md, f, k));
    end
    if (bw) begin m_addr[bs] = ba; m_arm[bs] = barm; end
  endtask

  task automatic send(logic [1:0] md, logic f, logic [1:0] k, logic [31:0] a, string t = "");
    cycle(1, md, f, k, a, 1, 0, 0, 0, 0, t);
  endtask

  task automatic wbp(logic [1:0] s, logic [31:0] a, logic arm);
    cycle(0, 0, 0, 0, 0, 1, 1, s, a, arm);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = 0;
    m_arm = 0;
    repeat (3) @(posedge clk);
    #1 chk("R9 valid in reset", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk); rst_n = 1;
    #1 chk("R9 valid after reset", {63'd0, rsp_valid}, 64'd0);
    // R9: slots at address 0 but disarmed, no hit
    send(2'b00, 0, 2'b00, 32'h0, "R9");
    // R1 directed
    send(2'b00, 1, 2'b00, 32'h0010_0000, "R1");
    send(2'b00, 1, 2'b01, 32'hFFFF_FFFF, "R1");
    // R2 directed
    send(2'b01, 1, 2'b00, 32'h0010_0000, "R2");
    send(2'b10, 1, 2'b01, 32'h0030_0004, "R2");
    send(2'b11, 1, 2'b00, 32'h0010_0008, "R2");
    // R3 directed
    send(2'b00, 1, 2'b10, 32'h0010_0000, "R3");
    send(2'b00, 1, 2'b11, 32'h0010_1000, "R3");
    // R4 directed
    send(2'b00, 0, 2'b01, 32'h0010_0040, "R4");
    // R5: compare on masked address
    wbp(0, 32'h0000_0010, 1);
    send(2'b00, 1, 2'b00, 32'h0010_0010, "R5");
    send(2'b01, 1, 2'b00, 32'h0010_0010, "R5");
    wbp(3, 32'h0010_0010, 1);
    send(2'b01, 1, 2'b00, 32'h0010_0010, "R5");
    // R6: disarm slot 0, same address no hit
    wbp(0, 32'h0000_0010, 0);
    send(2'b00, 1, 2'b00, 32'h0010_0010, "R6");
    // R10: write and request in the same cycle use old slot contents
    cycle(1, 2'b00, 0, 2'b00, 32'h0000_0400, 1, 1, 1, 32'h0000_0400, 1, "R10");
    send(2'b00, 0, 2'b00, 32'h0000_0400, "R10");
    // R8: stall the output for a few cycles
    cycle(1, 2'b00, 1, 2'b00, 32'h0012_3456, 0, 0, 0, 0, 0, "R8");
    cycle(1, 2'b00, 1, 2'b00, 32'h0000_0001, 0, 0, 0, 0, 0, "R8");
    cycle(0, 2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    cycle(0, 2'b00, 0, 2'b00, 0, 1, 0, 0, 0, 0);
    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [1:0]  s;
      s = 2'($urandom_range(3));
      a = m_addr[s] | (($urandom_range(1)) ? 32'h0010_0000 : 32'h0);
      if ($urandom_range(2) != 0) a = $urandom;
      cycle($urandom_range(3) != 0, 2'($urandom), $urandom_range(1) != 0, 2'($urandom), a,
            $urandom_range(3) != 0, $urandom_range(15) == 0, 2'($urandom),
            {11'd0, 1'($urandom), 16'd0, 4'($urandom)}, $urandom_range(3) != 0);
    end
    repeat (4) cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 drained", 64'(q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule